// File: doc/BRIEF.md
# USB Bulk IN Frame Packetizer

This block sits between a receive path that delivers Ethernet frames as a byte stream and a USB bulk IN endpoint whose packets carry at most 64 bytes. For every frame it writes a three-byte header into a single packet buffer: the receive status byte, then the frame length low byte, then the length high byte. The frame bytes follow. The header bytes occupy the first three places of the frame's first packet.

The host's IN tokens get one of three answers. A full buffer goes out as a 64-byte packet. A buffer whose frame has ended goes out as a short packet. Any other buffer gets a NAK. When a frame's header plus data is an exact multiple of 64 bytes, the next poll after the last full packet returns a zero-length packet that closes the frame. A packet stays in the buffer until the host acknowledges it. A handshake timeout leaves the buffer as it is, so the next token resends the same bytes. Bytes of two different frames never share a packet.

Top module: `usb_in_packetizer`

## Requirements
- R1: After reset `ep_valid`, `ep_last`, `ep_nak` and `frm_ready` are all low.
- R2: The first three bytes of a frame's first packet are `frm_status`, then `frm_len[7:0]`, then `frm_len[15:8]`. The frame bytes follow in the order they were accepted.
- R3: A token that finds the buffer holding 64 bytes is answered with exactly 64 data bytes, and `ep_last` is high on the 64th.
- R4: A token that finds the buffer below 64 bytes with its frame still open is answered with a one-cycle `ep_nak` in the cycle after the token, and no data. The same holds when nothing is pending at all.
- R5: A token that finds the frame ended and fewer than 64 bytes buffered is answered with exactly those bytes as a short packet.
- R6: When header plus frame length is a multiple of 64, the poll after the last full packet is acknowledged gets a zero-length packet. It is shown as one cycle of `ep_last` high with `ep_valid` low.
- R7: `in_timeout` after a packet keeps the buffer unchanged, and the next token resends the identical packet.
- R8: `in_ack` frees the buffer. Packets carry the header-and-frame byte sequence in order, and no packet holds bytes of two frames.
- R9: `frm_ready` stays low while the buffer is full, while it holds an ended frame, and while a zero-length packet is owed.
- R10: Data begins in the cycle after the token and continues with `ep_valid` high on every cycle up to `ep_last`.
- R11: A token that arrives while a packet is being sent or is waiting for its handshake produces neither a NAK nor data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | Frame byte present |
| frm_data | input | 8 | Frame byte |
| frm_last | input | 1 | Present byte is the last byte of the frame |
| frm_status | input | 8 | Receive status of the frame; held stable for the whole frame |
| frm_len | input | 16 | Frame byte count; held stable for the whole frame |
| frm_ready | output | 1 | Frame byte is taken at this clock edge |
| in_token | input | 1 | One-cycle IN token from the endpoint |
| in_ack | input | 1 | Host acknowledged the last packet |
| in_timeout | input | 1 | Handshake for the last packet never arrived |
| ep_valid | output | 1 | Packet data byte valid |
| ep_data | output | 8 | Packet data byte |
| ep_last | output | 1 | Last cycle of the packet; alone it marks a zero-length packet |
| ep_nak | output | 1 | Token answered with NAK |

## Verification
The hardest case to reach from the ports is the zero-length packet. It needs a frame whose header plus length lands exactly on a 64-byte boundary, with the last full packet of that frame acknowledged and not just timed out. The directed part feeds 61-byte and longer multiple-of-64 frames, then polls again after the acknowledge. The random part mixes such lengths with random lengths, random source gaps and random handshake timeouts, so retries also land on zero-length and boundary packets. A partly fed frame is held back on purpose to force the NAK-while-open case and the backpressure case.

// File: rtl/usb_inpk_pkg.sv
package usb_inpk_pkg;

  typedef enum logic [1:0] {
    PK_IDLE,
    PK_SEND,
    PK_WAIT
  } pk_state_e;

  // Answer to a token: packet length in bytes, or -1 for a NAK.
  function automatic int reply_len(int fill, bit ended, bit zlp_owed, int cap);
    if (fill == cap)  return cap;
    if (ended)        return fill;
    if (zlp_owed)     return 0;
    return -1;
  endfunction

  // A zero-length packet is owed after a full packet that closed its frame.
  function automatic bit zlp_after(int sent, bit ended, int cap);
    return (sent == cap) && ended;
  endfunction

  // Header byte by phase: status, then length low, then length high.
  function automatic logic [7:0] hdr_byte(logic [1:0] ph, logic [7:0] st,
                                          logic [15:0] len);
    case (ph)
      2'd0:    return st;
      2'd1:    return len[7:0];
      default: return len[15:8];
    endcase
  endfunction

endpackage

// File: rtl/usb_inpk_hdr.sv
module usb_inpk_hdr
  import usb_inpk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        allow,
  input  logic        frm_valid,
  input  logic [7:0]  frm_data,
  input  logic        frm_last,
  input  logic [7:0]  frm_status,
  input  logic [15:0] frm_len,
  output logic        frm_ready,
  output logic        wr_en,
  output logic [7:0]  wr_data,
  output logic        wr_eof
);
  localparam logic [1:0] PH_DATA = 2'd3;

  logic [1:0] ph;
  logic       in_data;

  assign in_data   = (ph == PH_DATA);
  assign wr_en     = allow && frm_valid;
  assign frm_ready = allow && in_data;
  assign wr_data   = in_data ? frm_data : hdr_byte(ph, frm_status, frm_len);
  assign wr_eof    = wr_en && in_data && frm_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= 2'd0;
    end else if (wr_en) begin
      if (!in_data)      ph <= ph + 2'd1;
      else if (frm_last) ph <= 2'd0;
    end
  end
endmodule

// File: rtl/usb_inpk_store.sv
module usb_inpk_store #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr == AW'(g))) mem[g] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/usb_inpk_ctrl.sv
module usb_inpk_ctrl
  import usb_inpk_pkg::*;
#(
  parameter int CAP = 64,
  localparam int CW = $clog2(CAP + 1),
  localparam int AW = $clog2(CAP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_eof,
  input  logic          in_token,
  input  logic          in_ack,
  input  logic          in_timeout,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          held,
  output logic          busy,
  output logic          ev_send_start,
  output logic          ep_valid,
  output logic          ep_last,
  output logic          ep_nak
);
  pk_state_e     st;
  logic [CW-1:0] fill_cnt, send_len;
  logic [AW-1:0] rd;
  logic          ended, zlp_owed, nak_q;
  logic          ev_nak, ev_free, ev_retry, send_done;
  int            rep;

  always_comb rep = reply_len(int'(fill_cnt), ended, zlp_owed, CAP);

  assign held          = (fill_cnt == CW'(CAP)) || ended || zlp_owed;
  assign busy          = (st != PK_IDLE);
  assign ev_send_start = (st == PK_IDLE) && in_token && (rep >= 0);
  assign ev_nak        = (st == PK_IDLE) && in_token && (rep < 0);
  assign ev_free       = (st == PK_WAIT) && in_ack;
  assign ev_retry      = (st == PK_WAIT) && !in_ack && in_timeout;
  assign send_done     = (st == PK_SEND) &&
                         ((send_len == '0) || (rd == AW'(send_len - 1'b1)));

  assign wr_addr  = fill_cnt[AW-1:0];
  assign rd_addr  = rd;
  assign ep_valid = (st == PK_SEND) && (send_len != '0);
  assign ep_last  = send_done;
  assign ep_nak   = nak_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= PK_IDLE;
      fill_cnt <= '0;
      send_len <= '0;
      rd       <= '0;
      ended    <= 1'b0;
      zlp_owed <= 1'b0;
      nak_q    <= 1'b0;
    end else begin
      nak_q <= ev_nak;
      if (ev_free) begin
        fill_cnt <= '0;
        ended    <= 1'b0;
        zlp_owed <= zlp_after(int'(send_len), ended, CAP);
      end else if (wr_en) begin
        fill_cnt <= fill_cnt + 1'b1;
        if (wr_eof) ended <= 1'b1;
      end
      case (st)
        PK_IDLE: if (ev_send_start) begin
          send_len <= CW'(rep);
          rd       <= '0;
          st       <= PK_SEND;
        end
        PK_SEND: begin
          if (send_done) st <= PK_WAIT;
          else           rd <= rd + 1'b1;
        end
        PK_WAIT: if (ev_free || ev_retry) st <= PK_IDLE;
        default: st <= PK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_in_packetizer.sv
module usb_in_packetizer #(
  parameter int PKT_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frm_valid,
  input  logic [7:0]  frm_data,
  input  logic        frm_last,
  input  logic [7:0]  frm_status,
  input  logic [15:0] frm_len,
  output logic        frm_ready,
  input  logic        in_token,
  input  logic        in_ack,
  input  logic        in_timeout,
  output logic        ep_valid,
  output logic [7:0]  ep_data,
  output logic        ep_last,
  output logic        ep_nak
);
  localparam int AW = $clog2(PKT_BYTES);

  logic          wr_en, wr_eof, held, busy, ev_send_start;
  logic [7:0]    wr_data;
  logic [AW-1:0] wr_addr, rd_addr;

  usb_inpk_hdr u_hdr (
    .clk, .rst_n,
    .allow(!held),
    .frm_valid, .frm_data, .frm_last, .frm_status, .frm_len,
    .frm_ready,
    .wr_en, .wr_data, .wr_eof
  );

  usb_inpk_store #(.DEPTH(PKT_BYTES)) u_store (
    .clk,
    .wr_en, .wr_addr, .wr_data,
    .rd_addr,
    .rd_data(ep_data)
  );

  usb_inpk_ctrl #(.CAP(PKT_BYTES)) u_ctrl (
    .clk, .rst_n,
    .wr_en, .wr_eof,
    .in_token, .in_ack, .in_timeout,
    .wr_addr, .rd_addr,
    .held, .busy, .ev_send_start,
    .ep_valid, .ep_last, .ep_nak
  );
endmodule

// File: rtl/usb_in_packetizer_chk.sv
module usb_in_packetizer_chk #(
  parameter int PKT_BYTES = 64
) (
  input logic clk,
  input logic rst_n,
  input logic frm_ready,
  input logic in_token,
  input logic ep_valid,
  input logic ep_last,
  input logic ep_nak,
  input logic held,
  input logic busy,
  input logic ev_send_start
);
  int beats;

  always_ff @(posedge clk) begin
    if (!rst_n)        beats <= 0;
    else if (ep_last)  beats <= 0;
    else if (ep_valid) beats <= beats + 1;
  end

  a_r3_max_len: assert property (@(posedge clk) disable iff (!rst_n)
    ep_valid |-> beats < PKT_BYTES);

  a_r4_nak_alone: assert property (@(posedge clk) disable iff (!rst_n)
    ep_nak |-> !ep_valid && !ep_last);

  a_r6_zlp_after_token: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_last && !ep_valid) |-> $past(ev_send_start));

  a_r9_no_fill_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !frm_ready);

  a_r10_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_valid && !ep_last) |=> ep_valid);

  a_r11_token_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_token) |=> !ep_nak);
endmodule

bind usb_in_packetizer usb_in_packetizer_chk #(.PKT_BYTES(PKT_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_ready(frm_ready), .in_token(in_token),
  .ep_valid(ep_valid), .ep_last(ep_last), .ep_nak(ep_nak),
  .held(held), .busy(busy), .ev_send_start(ev_send_start)
);

// File: tb/tb_usb_in_packetizer.sv
module tb_usb_in_packetizer;
  localparam int CAP = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frm_valid = 0, frm_last = 0, in_token = 0, in_ack = 0, in_timeout = 0;
  logic [7:0] frm_data = 0, frm_status = 0;
  logic [15:0] frm_len = 0;
  logic frm_ready, ep_valid, ep_last, ep_nak;
  logic [7:0] ep_data;

  always #4 clk = ~clk;

  usb_in_packetizer #(.PKT_BYTES(CAP)) dut (.*);

  int nchk = 0, nfail = 0;
  logic [7:0] exp_b [0:16383];
  int plen [0:1023];
  int f_off [0:63], f_len [0:63];
  logic [7:0] f_st [0:63];
  int nb = 0, npk = 0, nf = 0, eptr = 0, pk = 0;
  logic [7:0] rx [0:CAP-1];
  int rxn;
  bit rx_nak, rx_zlp, rx_gap;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Expected stream: header then data; packets cut at CAP, a final 0 means ZLP.
  task automatic add_frame(int len, logic [7:0] st);
    int t;
    f_off[nf] = nb; f_len[nf] = len; f_st[nf] = st;
    exp_b[nb] = st; exp_b[nb+1] = len[7:0]; exp_b[nb+2] = len[15:8];
    for (int i = 0; i < len; i++) exp_b[nb+3+i] = 8'($urandom);
    nb += len + 3;
    t = len + 3;
    while (t >= CAP) begin plen[npk] = CAP; npk++; t -= CAP; end
    plen[npk] = t; npk++;
    nf++;
  endtask

  task automatic feed(int f, int first, int cnt, int gap_pct);
    int i = first;
    while (i < first + cnt) begin
      @(negedge clk);
      if (int'($urandom % 100) < gap_pct) frm_valid = 0;
      else begin
        frm_valid = 1; frm_status = f_st[f]; frm_len = 16'(f_len[f]);
        frm_data = exp_b[f_off[f]+3+i]; frm_last = (i == f_len[f]-1);
        if (frm_ready) i++;
      end
    end
    @(negedge clk); frm_valid = 0; frm_last = 0;
  endtask

  task automatic poll();
    @(negedge clk); in_token = 1;
    @(negedge clk); in_token = 0;
    rx_nak = ep_nak; rx_zlp = ep_last && !ep_valid; rxn = 0; rx_gap = 0;
    if (ep_valid) begin
      while (1) begin
        rx[rxn] = ep_data; rxn++;
        if (ep_last || rxn >= CAP) break;
        @(negedge clk);
        if (!ep_valid) begin rx_gap = 1; break; end
      end
    end
  endtask

  task automatic handshake(bit ok);
    @(negedge clk); if (ok) in_ack = 1; else in_timeout = 1;
    @(negedge clk); in_ack = 0; in_timeout = 0;
  endtask

  task automatic check_pkt();
    int l = plen[pk], mm = -1;
    string req = (l == CAP) ? "R3" : (l == 0) ? "R6" : "R5";
    chk(!rx_nak && !rx_gap && rxn == l && (l != 0 || rx_zlp), req,
        "packet length", rxn, l);
    for (int i = 0; i < rxn && i < l; i++)
      if (mm < 0 && rx[i] != exp_b[eptr+i]) mm = i;
    chk(mm < 0, "R8", "byte order", (mm < 0) ? 0 : int'(rx[mm]),
        (mm < 0) ? 0 : int'(exp_b[eptr+mm]));
  endtask

  task automatic retire();
    handshake(1); eptr += plen[pk]; pk++;
  endtask

  task automatic drain(int to_pct);
    int guard = 0;
    while (pk < npk && guard < 5000) begin
      guard++;
      repeat ($urandom % 4) @(negedge clk);
      poll();
      if (rx_nak) continue;
      chk(rxn > 0 || rx_zlp, "R10", "response after token", rxn, 1);
      check_pkt();
      if (int'($urandom % 100) < to_pct) handshake(0);
      else retire();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R10", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!ep_valid && !ep_last && !ep_nak && !frm_ready, "R1", "outputs after reset",
        {ep_valid, ep_last, ep_nak, frm_ready}, 0);

    // Long frame fed in pieces: NAK while open, backpressure, retry, tail.
    add_frame(300, 8'hA5);
    feed(0, 0, 10, 0);
    poll();
    chk(rx_nak && rxn == 0, "R4", "nak while frame open", rxn, 0);
    feed(0, 10, 51, 0);
    @(negedge clk); frm_valid = 1; frm_data = exp_b[f_off[0]+3+61];
    repeat (3) @(negedge clk);
    chk(frm_ready == 0, "R9", "ready while buffer full", frm_ready, 0);
    frm_valid = 0;
    poll();
    check_pkt();
    chk(rx[0] == 8'hA5 && rx[1] == 8'd44 && rx[2] == 8'd1, "R2", "header bytes",
        {rx[0], rx[1], rx[2]}, {8'hA5, 8'd44, 8'd1});
    @(negedge clk); in_token = 1;
    @(negedge clk); in_token = 0;
    chk(!ep_nak && !ep_valid && !ep_last, "R11", "token while waiting",
        {ep_nak, ep_valid, ep_last}, 0);
    handshake(0);
    poll();
    chk(rxn == CAP && rx[0] == 8'hA5 && rx[3] == exp_b[3], "R7", "resent packet",
        rxn, CAP);
    retire();
    fork
      feed(0, 61, 239, 10);
      drain(0);
    join

    // Frame ending exactly on a packet boundary.
    add_frame(61, 8'h3C);
    feed(1, 0, 61, 0);
    poll(); check_pkt(); retire();
    poll();
    chk(rx_zlp && rxn == 0, "R6", "zero-length packet", rxn, 0);
    check_pkt(); retire();
    poll();
    chk(rx_nak && rxn == 0, "R4", "nak with nothing pending", rxn, 0);

    // Random frames with boundary lengths mixed in, gaps and timeouts.
    for (int k = 0; k < 22; k++) begin
      int l;
      case (k % 6)
        0: l = 125;
        1: l = 189;
        2: l = 1;
        default: l = 1 + int'($urandom % 300);
      endcase
      add_frame(l, 8'($urandom));
    end
    fork
      for (int f = 2; f < nf; f++) feed(f, 0, f_len[f], 25);
      drain(20);
    join
    chk(pk == npk && eptr == nb, "R8", "all packets delivered", eptr, nb);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule